// File: doc/BRIEF.md
# Horizontal Sync Edge and Clamp Window Generator

This block sits in the pixel-clock domain of a video capture front end. It takes a horizontal sync level that already changes only with the pixel clock, passes it through a two-stage synchronizer and finds its edges. A programmable sense bit chooses which edge is the leading one. Only the leading edge starts a line: it gives a one-cycle line-start pulse and a regenerated sync output whose level and length in pixel clocks are programmable.

The opposite, trailing edge times the black-level clamp window. After that edge a counter waits a programmed delay and then holds the window open for a programmed number of pixel clocks. A trailing edge that arrives while the counter is still running starts it again. If an enable bit is set, the clamp window comes from an external clamp input instead. That input has a programmable active level, and it is ignored while the enable bit is clear.

Internal clamp machine: states CLP_IDLE, CLP_DELAY and CLP_WINDOW. Transitions:
- Trailing edge with a non-zero duration and a zero delay: go to CLP_WINDOW.
- Trailing edge with a non-zero duration and a non-zero delay: go to CLP_DELAY.
- Trailing edge with a zero duration: go to CLP_IDLE.
- Delay count spent: go from CLP_DELAY to CLP_WINDOW.
- Window count spent: go from CLP_WINDOW to CLP_IDLE.

Sync output machine: states HS_IDLE and HS_PULSE. Transitions:
- Leading edge with a non-zero width: go to HS_PULSE, from either state (restart).
- Width count spent: go from HS_PULSE to HS_IDLE.

Top module: `hsync_clamp_timer`

## Requirements
- R1: While reset is asserted and right after it, `line_start` and `clamp_active` are 0 and `hsout` sits at its inactive level, which is `~cfg_hsout_pol`.
- R2: `cfg_hs_pol` picks the leading edge: 1 for rising, 0 for falling. Take the clock edge that first samples the new `hsync_in` level as edge 1. Then `line_start` is 1 for exactly one cycle, after edge 3.
- R3: A trailing edge of `hsync_in` never gives `line_start` and never starts `hsout`.
- R4: When `cfg_hsout_width` = W is not 0, `hsout` takes the level `cfg_hsout_pol` in the same cycle as `line_start` and holds it for W cycles. When W is 0, `hsout` stays inactive.
- R5: A leading edge that arrives while `hsout` is active restarts the width count. The pulse then ends W cycles after the new `line_start`.
- R6: With `cfg_ext_clamp_en` = 0, a trailing edge makes `clamp_active` 1 from edge 3+D to edge 3+D+L−1 and 0 from edge 3+D+L. Edges are counted as in R2, D is `cfg_clamp_delay` and L is `cfg_clamp_len`. D may be 0.
- R7: With `cfg_clamp_len` = 0, a trailing edge opens no clamp window.
- R8: A trailing edge that arrives during the delay or the window closes any open window. Timing then restarts from that edge as in R6.
- R9: With `cfg_ext_clamp_en` = 1, `clamp_active` equals (`clamp_ext_in` == `cfg_clamp_pol`), one clock after it is sampled. `cfg_clamp_pol` = 1 means active high.
- R10: With `cfg_ext_clamp_en` = 0, `clamp_ext_in` has no effect on `clamp_active`.
- R11: With `cfg_ext_clamp_en` = 1, the internal window never shows on `clamp_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync level |
| clamp_ext_in | input | 1 | External clamp level |
| cfg_hs_pol | input | 1 | Leading edge select: 1 rising, 0 falling |
| cfg_ext_clamp_en | input | 1 | 1 selects the external clamp input |
| cfg_clamp_pol | input | 1 | Active level of `clamp_ext_in` |
| cfg_clamp_delay | input | 8 | Clamp delay after trailing edge, in clocks |
| cfg_clamp_len | input | 8 | Clamp window length, in clocks |
| cfg_hsout_pol | input | 1 | Active level of `hsout` |
| cfg_hsout_width | input | 8 | `hsout` pulse width, in clocks |
| clamp_active | output | 1 | Clamp window strobe, active high |
| hsout | output | 1 | Regenerated horizontal sync |
| line_start | output | 1 | One-cycle pulse on each leading edge |

## Verification
The bench runs both edge senses and checks that the trailing edge never starts a line. A design that decoded the sense bit backwards would pulse `line_start` on the wrong edge. It checks the pulse and window boundaries cycle by cycle, with zero delay, zero length and zero width. Off-by-one counters, or a zero that wraps to 255, would show up there. It gives a second edge during a running `hsout` pulse and a second trailing edge during an open clamp window. A design that ignores the restart would end the pulse too early or leave the window open. Last, it toggles the external clamp input with the enable bit both set and clear, and it hides an internal window behind the enabled external path. A leaky multiplexer would show either source at the wrong time.

// File: rtl/hct_pkg.sv
package hct_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        CLP_IDLE   = 2'd0,
        CLP_DELAY  = 2'd1,
        CLP_WINDOW = 2'd2
    } clamp_state_t;

    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_PULSE = 1'b1
    } hsout_state_t;

endpackage

// File: rtl/hct_edge_detect.sv
module hct_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic cfg_rise_lead,
    output logic lead_o,
    output logic trail_o
);

    // synchronizer stages plus one history stage for edge compare
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] sync_q;
    logic [CHAIN-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            vld_q  <= '0;
        end else begin
            sync_q <= {sync_q[CHAIN-2:0], hsync_in};
            vld_q  <= {vld_q[CHAIN-2:0], 1'b1};
        end
    end

    logic cur_lvl;
    logic old_lvl;
    logic changed;

    always_comb begin
        cur_lvl = sync_q[CHAIN-2];
        old_lvl = sync_q[CHAIN-1];
        changed = vld_q[CHAIN-1] && (cur_lvl != old_lvl);
        lead_o  = changed && (cur_lvl == cfg_rise_lead);
        trail_o = changed && (cur_lvl != cfg_rise_lead);
    end

endmodule

// File: rtl/hct_hsout_fsm.sv
module hct_hsout_fsm
    import hct_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lead_i,
    input  logic [W-1:0] cfg_width,
    input  logic         cfg_pol,
    output logic         hsout_o
);

    hsout_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (lead_i) begin
            if (cfg_width != '0) begin
                state_d = HS_PULSE;
                cnt_d   = cfg_width - 1'b1;
            end else begin
                state_d = HS_IDLE;
                cnt_d   = '0;
            end
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    cnt_d = '0;
                end
                HS_PULSE: begin
                    if (cnt_q == '0) begin
                        state_d = HS_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = HS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        hsout_o = (state_q == HS_PULSE) ? cfg_pol : ~cfg_pol;
    end

endmodule

// File: rtl/hct_clamp_fsm.sv
module hct_clamp_fsm
    import hct_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trail_i,
    input  logic [W-1:0] cfg_delay,
    input  logic [W-1:0] cfg_len,
    output logic         window_o
);

    clamp_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state; a trailing edge restarts from any state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (trail_i) begin
            if (cfg_len == '0) begin
                state_d = CLP_IDLE;
                cnt_d   = '0;
            end else if (cfg_delay == '0) begin
                state_d = CLP_WINDOW;
                cnt_d   = cfg_len - 1'b1;
            end else begin
                state_d = CLP_DELAY;
                cnt_d   = cfg_delay - 1'b1;
            end
        end else begin
            unique case (state_q)
                CLP_IDLE: begin
                    cnt_d = '0;
                end
                CLP_DELAY: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (cfg_len == '0) begin
                        state_d = CLP_IDLE;
                    end else begin
                        state_d = CLP_WINDOW;
                        cnt_d   = cfg_len - 1'b1;
                    end
                end
                CLP_WINDOW: begin
                    if (cnt_q == '0) begin
                        state_d = CLP_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = CLP_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        window_o = (state_q == CLP_WINDOW);
    end

endmodule

// File: rtl/hsync_clamp_timer.sv
module hsync_clamp_timer
    import hct_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int W           = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hsync_in,
    input  logic         clamp_ext_in,
    input  logic         cfg_hs_pol,
    input  logic         cfg_ext_clamp_en,
    input  logic         cfg_clamp_pol,
    input  logic [W-1:0] cfg_clamp_delay,
    input  logic [W-1:0] cfg_clamp_len,
    input  logic         cfg_hsout_pol,
    input  logic [W-1:0] cfg_hsout_width,
    output logic         clamp_active,
    output logic         hsout,
    output logic         line_start
);

    logic lead;
    logic trail;
    logic int_window;
    logic ext_act_q;
    logic line_q;

    hct_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_in      (hsync_in),
        .cfg_rise_lead (cfg_hs_pol),
        .lead_o        (lead),
        .trail_o       (trail)
    );

    hct_hsout_fsm #(.W(W)) u_hsout (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_i    (lead),
        .cfg_width (cfg_hsout_width),
        .cfg_pol   (cfg_hsout_pol),
        .hsout_o   (hsout)
    );

    hct_clamp_fsm #(.W(W)) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .trail_i   (trail),
        .cfg_delay (cfg_clamp_delay),
        .cfg_len   (cfg_clamp_len),
        .window_o  (int_window)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            ext_act_q <= 1'b0;
        end else begin
            line_q    <= lead;
            ext_act_q <= (clamp_ext_in == cfg_clamp_pol);
        end
    end

    always_comb begin
        line_start   = line_q;
        clamp_active = cfg_ext_clamp_en ? ext_act_q : int_window;
    end

endmodule

// File: rtl/hct_checker.sv
module hct_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hsync_in,
    input logic         clamp_ext_in,
    input logic         cfg_hs_pol,
    input logic         cfg_ext_clamp_en,
    input logic         cfg_clamp_pol,
    input logic [W-1:0] cfg_clamp_len,
    input logic         cfg_hsout_pol,
    input logic [W-1:0] cfg_hsout_width,
    input logic         clamp_active,
    input logic         hsout,
    input logic         line_start
);

    logic [2:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 3'd4) age_q <= age_q + 3'd1;
    end

    // R2
    line_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // R3
    line_from_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && age_q == 3'd4) |->
            ($past(hsync_in, 3) == $past(cfg_hs_pol)) &&
            ($past(hsync_in, 4) != $past(cfg_hs_pol)));

    // R4
    hsout_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && cfg_hsout_width != '0) |-> (hsout == cfg_hsout_pol));

    // R9
    ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 3'd0 && cfg_ext_clamp_en) |->
            (clamp_active == ($past(clamp_ext_in) == $past(cfg_clamp_pol))));

    // R7
    no_len_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 3'd0 && !cfg_ext_clamp_en && $past(!cfg_ext_clamp_en) &&
         cfg_clamp_len == '0 && $past(cfg_clamp_len) == '0 &&
         !$past(clamp_active)) |-> !clamp_active);

endmodule

bind hsync_clamp_timer hct_checker #(.W(W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .hsync_in         (hsync_in),
    .clamp_ext_in     (clamp_ext_in),
    .cfg_hs_pol       (cfg_hs_pol),
    .cfg_ext_clamp_en (cfg_ext_clamp_en),
    .cfg_clamp_pol    (cfg_clamp_pol),
    .cfg_clamp_len    (cfg_clamp_len),
    .cfg_hsout_pol    (cfg_hsout_pol),
    .cfg_hsout_width  (cfg_hsout_width),
    .clamp_active     (clamp_active),
    .hsout            (hsout),
    .line_start       (line_start)
);

// File: tb/sim_hsync_clamp_timer.sv
`timescale 1ns/1ps
module sim_hsync_clamp_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b1;
    logic       clamp_ext_in = 1'b0;
    logic       cfg_hs_pol = 1'b0;
    logic       cfg_ext_clamp_en = 1'b0;
    logic       cfg_clamp_pol = 1'b1;
    logic [7:0] cfg_clamp_delay = 8'd0;
    logic [7:0] cfg_clamp_len = 8'd0;
    logic       cfg_hsout_pol = 1'b1;
    logic [7:0] cfg_hsout_width = 8'd4;
    logic       clamp_active, hsout, line_start;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hsync_clamp_timer u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .clamp_ext_in(clamp_ext_in),
        .cfg_hs_pol(cfg_hs_pol), .cfg_ext_clamp_en(cfg_ext_clamp_en),
        .cfg_clamp_pol(cfg_clamp_pol), .cfg_clamp_delay(cfg_clamp_delay),
        .cfg_clamp_len(cfg_clamp_len), .cfg_hsout_pol(cfg_hsout_pol),
        .cfg_hsout_width(cfg_hsout_width), .clamp_active(clamp_active),
        .hsout(hsout), .line_start(line_start)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int watch_line(input int n);
        return n;
    endfunction

    task automatic count_high(input int n, input bit use_clamp, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (use_clamp ? clamp_active : line_start) seen++;
        end
    endtask

    task automatic t_reset;
        chk("R1 line_start in reset", line_start, 1'b0);
        chk("R1 clamp_active in reset", clamp_active, 1'b0);
        chk("R1 hsout in reset", hsout, 1'b0);
        rst_n = 1'b1;
        tick(6);
        chk("R1 line_start after reset", line_start, 1'b0);
        chk("R1 hsout after reset", hsout, 1'b0);
    endtask

    task automatic t_fall_lead;
        int seen;
        hsync_in = 1'b0;
        tick(2);
        chk("R2 no early line_start", line_start, 1'b0);
        tick(1);
        chk("R2 line_start on falling", line_start, 1'b1);
        chk("R4 hsout starts", hsout, 1'b1);
        tick(1);
        chk("R2 line_start one cycle", line_start, 1'b0);
        tick(2);
        chk("R4 hsout last cycle", hsout, 1'b1);
        tick(1);
        chk("R4 hsout ended", hsout, 1'b0);
        hsync_in = 1'b1;
        count_high(10, 1'b0, seen);
        chk_int("R3 rising ignored when falling leads", seen, 0);
        chk("R3 hsout idle after trailing", hsout, 1'b0);
    endtask

    task automatic t_rise_lead;
        int seen;
        cfg_hs_pol = 1'b1;
        hsync_in = 1'b0;
        count_high(10, 1'b0, seen);
        chk_int("R3 falling ignored when rising leads", seen, 0);
        cfg_hsout_pol = 1'b0;
        cfg_hsout_width = 8'd2;
        tick(1);
        chk("R1 hsout inactive level follows pol", hsout, 1'b1);
        hsync_in = 1'b1;
        tick(3);
        chk("R2 line_start on rising", line_start, 1'b1);
        chk("R4 active-low hsout", hsout, 1'b0);
        tick(1);
        chk("R4 active-low hsout 2nd", hsout, 1'b0);
        tick(1);
        chk("R4 active-low hsout end", hsout, 1'b1);
    endtask

    task automatic t_width0;
        int lows;
        cfg_hsout_width = 8'd0;
        hsync_in = 1'b0;
        tick(8);
        hsync_in = 1'b1;
        tick(3);
        chk("R2 line_start width0", line_start, 1'b1);
        lows = 0;
        for (int i = 0; i < 6; i++) begin
            if (hsout == 1'b0) lows++;
            tick(1);
        end
        chk_int("R4 width zero no pulse", lows, 0);
    endtask

    task automatic t_restart_hs;
        cfg_hsout_pol = 1'b1;
        cfg_hsout_width = 8'd6;
        hsync_in = 1'b0;
        tick(8);
        hsync_in = 1'b1;
        tick(2);
        hsync_in = 1'b0;
        tick(2);
        hsync_in = 1'b1;
        tick(8);
        chk("R5 hsout extended by new lead", hsout, 1'b1);
        tick(1);
        chk("R5 hsout ends after restart", hsout, 1'b0);
    endtask

    task automatic t_clamp_basic;
        cfg_clamp_delay = 8'd3;
        cfg_clamp_len = 8'd4;
        hsync_in = 1'b0;
        tick(5);
        chk("R6 clamp not before delay", clamp_active, 1'b0);
        tick(1);
        chk("R6 clamp opens", clamp_active, 1'b1);
        tick(3);
        chk("R6 clamp last cycle", clamp_active, 1'b1);
        tick(1);
        chk("R6 clamp closes", clamp_active, 1'b0);
        cfg_clamp_delay = 8'd0;
        cfg_clamp_len = 8'd2;
        hsync_in = 1'b1;
        tick(8);
        hsync_in = 1'b0;
        tick(2);
        chk("R6 zero delay not early", clamp_active, 1'b0);
        tick(1);
        chk("R6 zero delay opens", clamp_active, 1'b1);
        tick(1);
        chk("R6 zero delay 2nd", clamp_active, 1'b1);
        tick(1);
        chk("R6 zero delay closes", clamp_active, 1'b0);
    endtask

    task automatic t_clamp_len0;
        int seen;
        hsync_in = 1'b1;
        tick(8);
        cfg_clamp_len = 8'd0;
        cfg_clamp_delay = 8'd1;
        hsync_in = 1'b0;
        count_high(15, 1'b1, seen);
        chk_int("R7 len zero no window", seen, 0);
    endtask

    task automatic t_clamp_restart;
        cfg_clamp_delay = 8'd2;
        cfg_clamp_len = 8'd5;
        hsync_in = 1'b1;
        tick(8);
        hsync_in = 1'b0;
        tick(1);
        hsync_in = 1'b1;
        tick(2);
        hsync_in = 1'b0;
        tick(2);
        chk("R6 first window opens", clamp_active, 1'b1);
        tick(1);
        chk("R8 restart closes window", clamp_active, 1'b0);
        tick(2);
        chk("R8 window reopens", clamp_active, 1'b1);
        tick(4);
        chk("R8 reopened last cycle", clamp_active, 1'b1);
        tick(1);
        chk("R8 reopened closes", clamp_active, 1'b0);
    endtask

    task automatic t_ext;
        int seen;
        cfg_ext_clamp_en = 1'b1;
        cfg_clamp_pol = 1'b1;
        clamp_ext_in = 1'b0;
        cfg_clamp_delay = 8'd0;
        cfg_clamp_len = 8'd3;
        hsync_in = 1'b1;
        tick(8);
        hsync_in = 1'b0;
        count_high(10, 1'b1, seen);
        chk_int("R11 internal window hidden", seen, 0);
        clamp_ext_in = 1'b1;
        tick(1);
        chk("R9 ext high active", clamp_active, 1'b1);
        clamp_ext_in = 1'b0;
        tick(1);
        chk("R9 ext low inactive", clamp_active, 1'b0);
        cfg_clamp_pol = 1'b0;
        tick(1);
        chk("R9 ext low active when pol=0", clamp_active, 1'b1);
        clamp_ext_in = 1'b1;
        tick(1);
        chk("R9 ext high inactive when pol=0", clamp_active, 1'b0);
        cfg_ext_clamp_en = 1'b0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            clamp_ext_in = i[0];
            tick(1);
            if (clamp_active) seen++;
        end
        chk_int("R10 ext ignored when disabled", seen, 0);
    endtask

    initial begin
        tick(4);
        t_reset();
        t_fall_lead();
        t_rise_lead();
        t_width0();
        t_restart_hs();
        t_clamp_basic();
        t_clamp_len0();
        t_clamp_restart();
        t_ext();
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule